// File: doc/BRIEF.md
# Service Bridge Dual-Port Register Bank

This block holds the 64-bit configuration and status registers of a service bridge. Two requesters reach the same bank. The scan port addresses the bank by byte offset, and the register index is that offset shifted right by three. The memory-mapped port decodes a window whose position and enable come from the bank's own base register. Its word index is biased by 0x0a, so window offset 0 lands on the base register. Every access moves one whole 64-bit word, and the low three address bits are ignored.

Beyond plain read/write registers, the bank has write-only alias indices. These AND or OR data into the fault register, or set and clear bits of the control register. Writable fields are masked per register. The base register accepts writes from the scan port only. The status register is read-only and shows a live input. The bank reports both rejected write kinds through a one-cycle error pulse. It exports the window enable and base, and it strobes the interrupt controller with the index slot and masked data of every routing or compare register write.

Each port has a valid/ready handshake. A write completes at the accepting edge. A read returns its data with a valid pulse on the following cycle. If both ports request in the same cycle, the scan port is served first.

Top module: `svc_bridge_regs`

## Requirements
- R1: Out of reset the base register holds RST_BAR masked with enable bit 0 set, routing slot k (k = 0 for index 0x10, k = 1..5 for indices 0x16..0x1a) holds priority bits 39:32 all ones and source bits 31:29 equal to k, and every other stored register holds zero.
- R2: Indices 0x00, 0x06, 0x07, 0x0f and 0x14 store all 64 written bits and read them back.
- R3: A write at index 0x01 ANDs the data into the fault register at 0x00, and a write at 0x02 ORs the data into it.
- R4: The control register at 0x0e is written directly, a write at 0x12 ORs the data into it, and a write at 0x13 clears the bits set in the data.
- R5: The base register at 0x0a keeps only bits 49:20 (mask 0x0003FFFFFFF00000) and bit 0. A memory-mapped write to it leaves it unchanged and pulses wr_err on the next cycle.
- R6: The secondary base register at 0x0b keeps only the bits in mask 0x0003FFFF00000000.
- R7: Index 0x15 reads stat_in. A write to it changes nothing and pulses wr_err on the next cycle.
- R8: Reads of any index that is not implemented return 0xFFFFFFFFFFFFFFFF. This covers the alias indices 0x01, 0x02, 0x12 and 0x13, memory-mapped indices at or above 0x20, and scan offsets with any bit above bit 7 set. Writes to such indices cause no strobe and no error.
- R9: Routing registers keep mask 0x00FFFFFFE0000000 and the compare register at 0x1b keeps mask 0xFFFFE00F00000000. Each write to one of them raises exactly route_stb bit k (compare is slot 6) on the next cycle, with route_data carrying the masked value.
- R10: A memory-mapped access hits only while bar_en is set and address bits PA_W-1:WIN_BITS equal those of the base register. Its index is (address bits WIN_BITS-1:3) + 0x0a. A miss reads all ones and writes nothing.
- R11: When both ports are valid in one cycle, only the scan access is accepted, mm_ready is low, and the memory-mapped access is served in a later cycle.
- R12: A read's data and rvalid appear on the port that issued it in the cycle after acceptance. A write produces no rvalid.
- R13: bar_en and bar_base follow the base register's enable bit and masked address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scn_valid | input | 1 | Scan port request |
| scn_ready | output | 1 | Scan port accept |
| scn_write | input | 1 | Scan port write (1) or read (0) |
| scn_addr | input | SCN_AW | Scan port byte offset |
| scn_wdata | input | 64 | Scan port write data |
| scn_rvalid | output | 1 | Scan read data valid |
| scn_rdata | output | 64 | Scan read data |
| mm_valid | input | 1 | Memory-mapped request |
| mm_ready | output | 1 | Memory-mapped accept |
| mm_write | input | 1 | Memory-mapped write (1) or read (0) |
| mm_addr | input | PA_W | Memory-mapped physical byte address |
| mm_wdata | input | 64 | Memory-mapped write data |
| mm_rvalid | output | 1 | Memory-mapped read data valid |
| mm_rdata | output | 64 | Memory-mapped read data |
| stat_in | input | 64 | Live interrupt status shown at index 0x15 |
| bar_en | output | 1 | Window enable from base register bit 0 |
| bar_base | output | PA_W | Window base address (enable bit cleared) |
| route_stb | output | 7 | One-cycle strobe per routing/compare slot written |
| route_data | output | 64 | Masked value of the last routing/compare write |
| wr_err | output | 1 | One-cycle pulse on a rejected write |

## Verification
The bench builds the bank with PA_W = 50 and WIN_BITS = 20, so the derived base and secondary-base masks equal the stated constants. RST_BAR = 0x0003FFFE80000000 opens the window out of reset, which lets memory-mapped reads reach the reset values before any configuration is written. SCN_AW = 9 adds one scan address bit above the 256-byte bank, and this brings the aliased upper half into reach as an unimplemented range. Moving and then disabling the base register exercises window misses both at the old address and while the window is closed.

// File: rtl/svc_bridge_pkg.sv
package svc_bridge_pkg;

   localparam int IDX_W   = 5;
   localparam int DW      = 64;
   localparam int ROUTE_N = 7;

   localparam logic [IDX_W-1:0] IX_FAULT     = 5'h00;
   localparam logic [IDX_W-1:0] IX_FAULT_AND = 5'h01;
   localparam logic [IDX_W-1:0] IX_FAULT_OR  = 5'h02;
   localparam logic [IDX_W-1:0] IX_ACT0      = 5'h06;
   localparam logic [IDX_W-1:0] IX_ACT1      = 5'h07;
   localparam logic [IDX_W-1:0] IX_BASE      = 5'h0a;
   localparam logic [IDX_W-1:0] IX_SBASE     = 5'h0b;
   localparam logic [IDX_W-1:0] IX_CTL       = 5'h0e;
   localparam logic [IDX_W-1:0] IX_ERRMASK   = 5'h0f;
   localparam logic [IDX_W-1:0] IX_CTL_SET   = 5'h12;
   localparam logic [IDX_W-1:0] IX_CTL_CLR   = 5'h13;
   localparam logic [IDX_W-1:0] IX_DMAHI     = 5'h14;
   localparam logic [IDX_W-1:0] IX_STAT      = 5'h15;
   localparam logic [IDX_W-1:0] IX_CMP       = 5'h1b;

   // memory-mapped word 0 maps onto the base register
   localparam logic [IDX_W-1:0] MM_IDX_BIAS = IX_BASE;

   localparam logic [DW-1:0] RT_KEEP     = 64'h00FF_FFFF_E000_0000;
   localparam logic [DW-1:0] CMP_KEEP    = 64'hFFFF_E00F_0000_0000;
   localparam logic [DW-1:0] RT_PRIO_ALL = 64'h0000_00FF_0000_0000;
   localparam int            RT_SRC_LSB  = 29;

   // slot 0 sits alone at 0x10, slots 1..6 follow contiguously from 0x16
   function automatic logic [IDX_W-1:0] route_index(input int s);
      return (s == 0) ? 5'h10 : IDX_W'(32'h15 + s);
   endfunction

   function automatic logic [DW-1:0] route_keep(input int s);
      return (s == ROUTE_N - 1) ? CMP_KEEP : RT_KEEP;
   endfunction

   function automatic logic [DW-1:0] route_rst(input int s);
      return (s == ROUTE_N - 1) ? '0 : (RT_PRIO_ALL | (DW'(s) << RT_SRC_LSB));
   endfunction

   typedef struct packed {
      logic             fire;
      logic             write;
      logic             hit;
      logic             from_mm;
      logic [IDX_W-1:0] idx;
      logic [DW-1:0]    wdata;
   } acc_t;

endpackage

// File: rtl/svc_bridge_arb.sv
module svc_bridge_arb
   import svc_bridge_pkg::*;
#(
   parameter int PA_W     = 50,
   parameter int WIN_BITS = 20,
   parameter int SCN_AW   = 8
) (
   input  logic              scn_valid,
   input  logic              scn_write,
   input  logic [SCN_AW-1:0] scn_addr,
   input  logic [DW-1:0]     scn_wdata,
   input  logic              mm_valid,
   input  logic              mm_write,
   input  logic [PA_W-1:0]   mm_addr,
   input  logic [DW-1:0]     mm_wdata,
   input  logic              bar_en,
   input  logic [PA_W-1:0]   bar_base,
   output logic              scn_ready,
   output logic              mm_ready,
   output acc_t              acc
);

   localparam int BANK_AW = IDX_W + 3;
   localparam int WORD_W  = WIN_BITS - 3;
   localparam int SUM_W   = WORD_W + 1;

   generate
      if (WIN_BITS < BANK_AW || WIN_BITS >= PA_W) begin : g_bad_win
         $error("svc_bridge_arb: WIN_BITS out of range");
      end
      if (SCN_AW < BANK_AW) begin : g_bad_scn
         $error("svc_bridge_arb: SCN_AW too narrow for the bank");
      end
   endgenerate

   logic [SUM_W-1:0] mm_word_idx;
   logic             mm_in_win;
   logic             mm_in_bank;
   logic             scn_in_bank;
   logic             unused_low;

   assign mm_word_idx = SUM_W'(mm_addr[WIN_BITS-1:3]) + SUM_W'(MM_IDX_BIAS);
   assign mm_in_win   = bar_en && (mm_addr[PA_W-1:WIN_BITS] == bar_base[PA_W-1:WIN_BITS]);
   assign mm_in_bank  = (mm_word_idx[SUM_W-1:IDX_W] == '0);
   assign unused_low  = ^{scn_addr[2:0], mm_addr[2:0], bar_base[WIN_BITS-1:0]};

   generate
      if (SCN_AW > BANK_AW) begin : g_scn_wide
         assign scn_in_bank = (scn_addr[SCN_AW-1:BANK_AW] == '0);
      end else begin : g_scn_exact
         assign scn_in_bank = 1'b1;
      end
   endgenerate

   assign scn_ready = 1'b1;
   assign mm_ready  = ~scn_valid;

   always_comb begin
      acc = '0;
      if (scn_valid) begin
         acc.fire    = 1'b1;
         acc.write   = scn_write;
         acc.hit     = scn_in_bank;
         acc.from_mm = 1'b0;
         acc.idx     = scn_addr[BANK_AW-1:3];
         acc.wdata   = scn_wdata;
      end else if (mm_valid) begin
         acc.fire    = 1'b1;
         acc.write   = mm_write;
         acc.hit     = mm_in_win && mm_in_bank;
         acc.from_mm = 1'b1;
         acc.idx     = mm_word_idx[IDX_W-1:0];
         acc.wdata   = mm_wdata;
      end
   end

endmodule

// File: rtl/svc_bridge_core.sv
module svc_bridge_core
   import svc_bridge_pkg::*;
#(
   parameter int          PA_W     = 50,
   parameter int          WIN_BITS = 20,
   parameter logic [63:0] RST_BAR  = 64'h0003_FFFE_8000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  acc_t               acc,
   input  logic [DW-1:0]      stat_in,
   output logic [DW-1:0]      rd_val,
   output logic               bar_en,
   output logic [PA_W-1:0]    bar_base,
   output logic [ROUTE_N-1:0] route_stb,
   output logic [DW-1:0]      route_data,
   output logic               wr_err
);

   localparam logic [DW-1:0] PA_ONES    = (64'd1 << PA_W) - 64'd1;
   localparam logic [DW-1:0] BASE_KEEP  = (PA_ONES & ~((64'd1 << WIN_BITS) - 64'd1)) | 64'd1;
   localparam logic [DW-1:0] SBASE_KEEP = PA_ONES & ~((64'd1 << 32) - 64'd1);
   localparam logic [DW-1:0] BASE_RST   = (RST_BAR & BASE_KEEP) | 64'd1;

   logic [DW-1:0] fault_q, act0_q, act1_q, base_q, sbase_q;
   logic [DW-1:0] ctl_q, emask_q, dmahi_q;
   logic [DW-1:0] rt_q [ROUTE_N];
   logic [ROUTE_N-1:0] slot_we;
   logic          wr;
   logic          bad_wr;
   logic [DW-1:0] fwd_val;

   assign wr     = acc.fire && acc.write && acc.hit;
   assign bad_wr = wr && ((acc.idx == IX_STAT) || ((acc.idx == IX_BASE) && acc.from_mm));

   generate
      for (genvar s = 0; s < ROUTE_N; s++) begin : g_slot
         assign slot_we[s] = wr && (acc.idx == route_index(s));
      end
   endgenerate

   assign fwd_val = acc.wdata & ((acc.idx == IX_CMP) ? CMP_KEEP : RT_KEEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_q <= '0;
         act0_q  <= '0;
         act1_q  <= '0;
         base_q  <= BASE_RST;
         sbase_q <= '0;
         ctl_q   <= '0;
         emask_q <= '0;
         dmahi_q <= '0;
      end else if (wr) begin
         case (acc.idx)
            IX_FAULT:     fault_q <= acc.wdata;
            IX_FAULT_AND: fault_q <= fault_q & acc.wdata;
            IX_FAULT_OR:  fault_q <= fault_q | acc.wdata;
            IX_ACT0:      act0_q  <= acc.wdata;
            IX_ACT1:      act1_q  <= acc.wdata;
            IX_BASE:      if (!acc.from_mm) base_q <= acc.wdata & BASE_KEEP;
            IX_SBASE:     sbase_q <= acc.wdata & SBASE_KEEP;
            IX_CTL:       ctl_q   <= acc.wdata;
            IX_CTL_SET:   ctl_q   <= ctl_q | acc.wdata;
            IX_CTL_CLR:   ctl_q   <= ctl_q & ~acc.wdata;
            IX_ERRMASK:   emask_q <= acc.wdata;
            IX_DMAHI:     dmahi_q <= acc.wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < ROUTE_N; s++) rt_q[s] <= route_rst(s);
         route_stb  <= '0;
         route_data <= '0;
         wr_err     <= 1'b0;
      end else begin
         for (int s = 0; s < ROUTE_N; s++) begin
            if (slot_we[s]) rt_q[s] <= acc.wdata & route_keep(s);
         end
         route_stb <= slot_we;
         if (|slot_we) route_data <= fwd_val;
         wr_err <= bad_wr;
      end
   end

   always_comb begin
      rd_val = '1;
      if (acc.hit) begin
         case (acc.idx)
            IX_FAULT:   rd_val = fault_q;
            IX_ACT0:    rd_val = act0_q;
            IX_ACT1:    rd_val = act1_q;
            IX_BASE:    rd_val = base_q;
            IX_SBASE:   rd_val = sbase_q;
            IX_CTL:     rd_val = ctl_q;
            IX_ERRMASK: rd_val = emask_q;
            IX_DMAHI:   rd_val = dmahi_q;
            IX_STAT:    rd_val = stat_in;
            default: ;
         endcase
         for (int s = 0; s < ROUTE_N; s++) begin
            if (acc.idx == route_index(s)) rd_val = rt_q[s];
         end
      end
   end

   assign bar_en   = base_q[0];
   assign bar_base = {base_q[PA_W-1:1], 1'b0};

   AST_AND_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && acc.idx == IX_FAULT_AND) |=> ((fault_q & ~$past(fault_q)) == '0)); // R3
   AST_CLR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && acc.idx == IX_CTL_CLR) |=> ((ctl_q & ~$past(ctl_q)) == '0)); // R4
   AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && acc.idx == IX_CTL_SET) |=> (($past(ctl_q) & ~ctl_q) == '0)); // R4
   AST_MM_BASE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && acc.from_mm && acc.idx == IX_BASE) |=> ($stable(base_q) && wr_err)); // R5
   AST_STAT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.fire && acc.write && acc.hit && acc.idx == IX_STAT) |=> wr_err); // R7
   AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(route_stb)); // R9

endmodule

// File: rtl/svc_bridge_regs.sv
module svc_bridge_regs
   import svc_bridge_pkg::*;
#(
   parameter int          PA_W     = 50,
   parameter int          WIN_BITS = 20,
   parameter int          SCN_AW   = 8,
   parameter logic [63:0] RST_BAR  = 64'h0003_FFFE_8000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scn_valid,
   output logic               scn_ready,
   input  logic               scn_write,
   input  logic [SCN_AW-1:0]  scn_addr,
   input  logic [63:0]        scn_wdata,
   output logic               scn_rvalid,
   output logic [63:0]        scn_rdata,
   input  logic               mm_valid,
   output logic               mm_ready,
   input  logic               mm_write,
   input  logic [PA_W-1:0]    mm_addr,
   input  logic [63:0]        mm_wdata,
   output logic               mm_rvalid,
   output logic [63:0]        mm_rdata,
   input  logic [63:0]        stat_in,
   output logic               bar_en,
   output logic [PA_W-1:0]    bar_base,
   output logic [ROUTE_N-1:0] route_stb,
   output logic [63:0]        route_data,
   output logic               wr_err
);

   generate
      if (PA_W <= 32 || PA_W > 63) begin : g_bad_pa
         $error("svc_bridge_regs: PA_W must be within 33..63");
      end
   endgenerate

   acc_t          acc;
   logic [DW-1:0] rd_val;

   svc_bridge_arb #(
      .PA_W     (PA_W),
      .WIN_BITS (WIN_BITS),
      .SCN_AW   (SCN_AW)
   ) u_arb (
      .scn_valid (scn_valid),
      .scn_write (scn_write),
      .scn_addr  (scn_addr),
      .scn_wdata (scn_wdata),
      .mm_valid  (mm_valid),
      .mm_write  (mm_write),
      .mm_addr   (mm_addr),
      .mm_wdata  (mm_wdata),
      .bar_en    (bar_en),
      .bar_base  (bar_base),
      .scn_ready (scn_ready),
      .mm_ready  (mm_ready),
      .acc       (acc)
   );

   svc_bridge_core #(
      .PA_W     (PA_W),
      .WIN_BITS (WIN_BITS),
      .RST_BAR  (RST_BAR)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc        (acc),
      .stat_in    (stat_in),
      .rd_val     (rd_val),
      .bar_en     (bar_en),
      .bar_base   (bar_base),
      .route_stb  (route_stb),
      .route_data (route_data),
      .wr_err     (wr_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scn_rvalid <= 1'b0;
         mm_rvalid  <= 1'b0;
         scn_rdata  <= '0;
         mm_rdata   <= '0;
      end else begin
         scn_rvalid <= acc.fire && !acc.write && !acc.from_mm;
         mm_rvalid  <= acc.fire && !acc.write && acc.from_mm;
         if (acc.fire && !acc.write && !acc.from_mm) scn_rdata <= rd_val;
         if (acc.fire && !acc.write && acc.from_mm)  mm_rdata  <= rd_val;
      end
   end

   AST_MM_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      mm_rvalid |-> $past(mm_valid && mm_ready && !mm_write)); // R12
   AST_SCN_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      scn_rvalid |-> $past(scn_valid && !scn_write)); // R12
   AST_ONE_PORT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({scn_rvalid, mm_rvalid})); // R11

endmodule

// File: tb/svc_bridge_regs_bench.sv
`timescale 1ns/1ps
module svc_bridge_regs_bench;

   localparam int PA_W     = 50;
   localparam int WIN_BITS = 20;
   localparam int SCN_AW   = 9;
   localparam logic [63:0] RBAR = 64'h0003_FFFE_8000_0000;
   localparam logic [63:0] B    = RBAR;
   localparam logic [63:0] NB   = 64'h0003_FFFF_FFF0_0000;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam int NV = 32;

   // {mm, write, addr[63:0], data/expected[63:0]}
   localparam logic [129:0] VEC [NV] = '{
      {1'b0, 1'b1, 64'h000, 64'hF0F0_0000_0000_00FF},   // R2
      {1'b0, 1'b0, 64'h000, 64'hF0F0_0000_0000_00FF},   // R2
      {1'b0, 1'b1, 64'h008, 64'hFFFF_0000_0000_000F},   // R3 AND
      {1'b0, 1'b0, 64'h000, 64'hF0F0_0000_0000_000F},   // R3
      {1'b0, 1'b1, 64'h010, 64'h0000_0000_0000_0F00},   // R3 OR
      {1'b0, 1'b0, 64'h000, 64'hF0F0_0000_0000_0F0F},   // R3
      {1'b0, 1'b1, 64'h070, 64'h8000_0000_0000_0001},   // R4
      {1'b0, 1'b1, 64'h090, 64'h0000_0000_0000_0010},   // R4 set
      {1'b0, 1'b0, 64'h070, 64'h8000_0000_0000_0011},   // R4
      {1'b0, 1'b1, 64'h098, 64'h8000_0000_0000_0001},   // R4 clear
      {1'b0, 1'b0, 64'h070, 64'h0000_0000_0000_0010},   // R4
      {1'b0, 1'b1, 64'h058, ONES},                      // R6
      {1'b0, 1'b0, 64'h058, 64'h0003_FFFF_0000_0000},   // R6
      {1'b0, 1'b0, 64'h018, ONES},                      // R8
      {1'b0, 1'b0, 64'h090, ONES},                      // R8 alias
      {1'b0, 1'b0, 64'h170, ONES},                      // R8 upper scan bit
      {1'b1, 1'b0, B + 64'h00, 64'h0003_FFFE_8000_0001}, // R1 base
      {1'b1, 1'b1, B + 64'h20, 64'h0000_0000_0000_0055}, // R10
      {1'b0, 1'b0, 64'h070, 64'h0000_0000_0000_0055},   // R10
      {1'b1, 1'b0, B + 64'h30, 64'h0000_00FF_0000_0000}, // R1 slot 0
      {1'b1, 1'b0, B + 64'h80, 64'h0000_00FF_A000_0000}, // R1 slot 5
      {1'b1, 1'b0, B + 64'hB0, ONES},                   // R8 index 0x20
      {1'b0, 1'b1, 64'h0D8, ONES},                      // R9
      {1'b0, 1'b0, 64'h0D8, 64'hFFFF_E00F_0000_0000},   // R9
      {1'b0, 1'b1, 64'h080, ONES},                      // R9
      {1'b1, 1'b0, B + 64'h30, 64'h00FF_FFFF_E000_0000}, // R9
      {1'b0, 1'b1, 64'h078, 64'h1234_5678_9ABC_DEF0},   // R2
      {1'b0, 1'b0, 64'h078, 64'h1234_5678_9ABC_DEF0},   // R2
      {1'b1, 1'b1, B + 64'h50, 64'h0000_0000_0000_DEAD}, // R10
      {1'b0, 1'b0, 64'h0A0, 64'h0000_0000_0000_DEAD},   // R10
      {1'b0, 1'b1, 64'h030, 64'hA5A5_A5A5_A5A5_A5A5},   // R2
      {1'b0, 1'b0, 64'h030, 64'hA5A5_A5A5_A5A5_A5A5}    // R2
   };
   localparam int VREQ [NV] = '{2,2,3,3,3,3,4,4,4,4,4,6,6,8,8,8,
                                1,10,10,1,1,8,9,9,9,9,2,2,10,10,2,2};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              scn_valid = 1'b0, scn_write = 1'b0;
   logic [SCN_AW-1:0] scn_addr = '0;
   logic [63:0]       scn_wdata = '0;
   logic              scn_ready, scn_rvalid;
   logic [63:0]       scn_rdata;
   logic              mm_valid = 1'b0, mm_write = 1'b0;
   logic [PA_W-1:0]   mm_addr = '0;
   logic [63:0]       mm_wdata = '0;
   logic              mm_ready, mm_rvalid;
   logic [63:0]       mm_rdata;
   logic [63:0]       stat_in = '0;
   logic              bar_en;
   logic [PA_W-1:0]   bar_base;
   logic [6:0]        route_stb;
   logic [63:0]       route_data;
   logic              wr_err;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   svc_bridge_regs #(
      .PA_W (PA_W), .WIN_BITS (WIN_BITS), .SCN_AW (SCN_AW), .RST_BAR (RBAR)
   ) u_svc_bridge_regs (
      .clk (clk), .rst_n (rst_n),
      .scn_valid (scn_valid), .scn_ready (scn_ready), .scn_write (scn_write),
      .scn_addr (scn_addr), .scn_wdata (scn_wdata),
      .scn_rvalid (scn_rvalid), .scn_rdata (scn_rdata),
      .mm_valid (mm_valid), .mm_ready (mm_ready), .mm_write (mm_write),
      .mm_addr (mm_addr), .mm_wdata (mm_wdata),
      .mm_rvalid (mm_rvalid), .mm_rdata (mm_rdata),
      .stat_in (stat_in), .bar_en (bar_en), .bar_base (bar_base),
      .route_stb (route_stb), .route_data (route_data), .wr_err (wr_err)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive at a falling edge, return at the next falling edge (one rising edge later)
   task automatic do_acc(input bit mm, input bit wr, input logic [63:0] a, input logic [63:0] d);
      @(negedge clk);
      if (mm) begin
         mm_valid = 1'b1; mm_write = wr; mm_addr = a[PA_W-1:0]; mm_wdata = d;
      end else begin
         scn_valid = 1'b1; scn_write = wr; scn_addr = a[SCN_AW-1:0]; scn_wdata = d;
      end
      @(negedge clk);
      scn_valid = 1'b0;
      mm_valid  = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R12 watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 / R13: reset state
      chk("R13 bar_en reset", 64'(bar_en), 64'd1);
      chk("R13 bar_base reset", 64'(bar_base), RBAR);
      chk("R1 route_stb reset", 64'(route_stb), 64'd0);
      chk("R1 wr_err reset", 64'(wr_err), 64'd0);
      chk("R12 rvalid reset", 64'({scn_rvalid, mm_rvalid}), 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         automatic bit          vmm = VEC[i][129];
         automatic bit          vwr = VEC[i][128];
         automatic logic [63:0] va  = VEC[i][127:64];
         automatic logic [63:0] vd  = VEC[i][63:0];
         automatic string       tg  = $sformatf("R%0d vec%0d", VREQ[i], i);
         do_acc(vmm, vwr, va, vd);
         if (vwr) begin
            chk({tg, " no rvalid"}, 64'(vmm ? mm_rvalid : scn_rvalid), 64'd0);
         end else begin
            chk({tg, " rvalid"}, 64'(vmm ? mm_rvalid : scn_rvalid), 64'd1);
            chk(tg, vmm ? mm_rdata : scn_rdata, vd);
         end
      end

      // R9: routing strobe slot 1 (index 0x16) and compare slot 6
      do_acc(1'b0, 1'b1, 64'h0B0, ONES);
      chk("R9 stb slot1", 64'(route_stb), 64'h02);
      chk("R9 data slot1", route_data, 64'h00FF_FFFF_E000_0000);
      do_acc(1'b0, 1'b1, 64'h0D8, 64'h1234_5678_9ABC_DEF0);
      chk("R9 stb cmp", 64'(route_stb), 64'h40);
      chk("R9 data cmp", route_data, 64'h1234_5678_9ABC_DEF0 & 64'hFFFF_E00F_0000_0000);

      // R7: status read-only
      stat_in = 64'h0000_001F_0000_0000;
      do_acc(1'b0, 1'b0, 64'h0A8, 64'h0);
      chk("R7 stat read", scn_rdata, 64'h0000_001F_0000_0000);
      do_acc(1'b0, 1'b1, 64'h0A8, 64'h0);
      chk("R7 stat write err", 64'(wr_err), 64'd1);
      do_acc(1'b0, 1'b0, 64'h0A8, 64'h0);
      chk("R7 stat unchanged", scn_rdata, 64'h0000_001F_0000_0000);
      chk("R7 err one pulse", 64'(wr_err), 64'd0);

      // R5: base not writable from memory-mapped port
      do_acc(1'b1, 1'b1, B, 64'h0);
      chk("R5 mm base err", 64'(wr_err), 64'd1);
      chk("R5 mm base kept", 64'(bar_en), 64'd1);
      do_acc(1'b0, 1'b1, 64'h050, ONES);
      chk("R13 bar_base moved", 64'(bar_base), NB);
      chk("R5 scan base no err", 64'(wr_err), 64'd0);
      do_acc(1'b0, 1'b0, 64'h050, 64'h0);
      chk("R5 base masked", scn_rdata, 64'h0003_FFFF_FFF0_0001);

      // R10: window follows base register
      do_acc(1'b1, 1'b0, B + 64'h20, 64'h0);
      chk("R10 old window miss", mm_rdata, ONES);
      do_acc(1'b1, 1'b0, NB + 64'h20, 64'h0);
      chk("R10 new window hit", mm_rdata, 64'h55);
      do_acc(1'b0, 1'b1, 64'h050, 64'h0);
      chk("R13 bar_en off", 64'(bar_en), 64'd0);
      do_acc(1'b1, 1'b0, NB + 64'h20, 64'h0);
      chk("R10 disabled read", mm_rdata, ONES);
      do_acc(1'b1, 1'b1, NB + 64'h20, 64'h77);
      do_acc(1'b0, 1'b0, 64'h070, 64'h0);
      chk("R10 disabled write ignored", scn_rdata, 64'h55);

      // R8: unimplemented write has no side effect
      do_acc(1'b0, 1'b1, 64'h0E0, ONES);
      chk("R8 no strobe", 64'(route_stb), 64'd0);
      chk("R8 no err", 64'(wr_err), 64'd0);

      // R11: simultaneous requests
      do_acc(1'b0, 1'b1, 64'h050, RBAR | 64'd1);
      @(negedge clk);
      scn_valid = 1'b1; scn_write = 1'b0; scn_addr = 9'h070;
      mm_valid  = 1'b1; mm_write  = 1'b0; mm_addr  = PA_W'(B + 64'h20);
      #1;
      chk("R11 mm_ready low", 64'(mm_ready), 64'd0);
      @(negedge clk);
      chk("R11 scan served", 64'({scn_rvalid, mm_rvalid}), 64'b10);
      chk("R11 scan data", scn_rdata, 64'h55);
      scn_valid = 1'b0;
      @(negedge clk);
      chk("R11 mm served later", 64'({scn_rvalid, mm_rvalid}), 64'b01);
      chk("R12 mm data", mm_rdata, 64'h55);
      mm_valid = 1'b0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule